// File: doc/BRIEF.md
# Byte-wide nonvolatile data write sequencer

This block sits between a small register interface and a byte-addressed nonvolatile data array. Software loads a 16-bit pointer (as two byte registers) and one data byte, arms the write through a write-enable bit and then sets a start bit in the control register. After a fixed number of programming-clock falling edges, the block drives the array through an erase step, a program step and a discharge wait. When all three are over it clears the start bit by itself, and software sees completion by polling that bit.

The array is not inside the block. The block drives a registered write strobe, an address and a data byte to an external register file. The erase step writes the erased value 0xFF to the location, and the program step then writes the latched byte there. Erase, program and discharge lengths are parameters counted in system clocks. The pointer is reduced to the array depth before it reaches the array.

Top module: `nvbyte_write_ctrl`

## Requirements
- R1: After reset, busy, done and arr_we are 0, and all four registers read as 0x00.
- R2: Register offsets on reg_addr are 0 control, 1 pointer low byte, 2 pointer high byte, 3 data byte. Control bit 7 is the memory-region select, bit 6 the configuration select, bit 2 the write enable and bit 1 the start bit. The other control bits read 0. reg_rdata shows the register addressed in the previous cycle.
- R3: A control write with bit 1 set starts a write only when the stored enable bit is already 1 and the written value has bit 2 = 1 and bits 7:6 = 00. busy goes to 1 in the next cycle, and the start bit reads 1 while busy.
- R4: Any other control write with bit 1 set is ignored. busy stays 0, the array is not written, and the start bit returns to 0 one cycle after the write. The other control bits still take the written value.
- R5: After a start, the array is not written until the START_FALLS-th (4th) falling edge of prog_clk seen after the start. Rising edges do not count.
- R6: From that edge on, arr_we is high for ERASE_CYC cycles with arr_wdata = 0xFF, and then at once for PROG_CYC cycles with the latched data byte. Both phases target the same address.
- R7: After programming, busy stays 1 until prog_clk has been sampled low on HOLD_CYC consecutive clocks. A high sample restarts this count. busy then falls and done pulses high for exactly one cycle.
- R8: The start bit is cleared by hardware when the write ends, and reads 0 once busy is low again.
- R9: While busy, writes to the pointer, data and region bits are ignored. A control write may clear the enable bit, and this does not stop the write in progress.
- R10: arr_addr is the 16-bit pointer modulo DEPTH (its low log2(DEPTH) bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data of the offset from the previous cycle |
| prog_clk | input | 1 | Programming clock level, sampled on clk |
| busy | output | 1 | A write sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a write |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | AW (7) | Array byte address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with DEPTH = 128 and shortens the phases to ERASE_CYC = 3, PROG_CYC = 5 and HOLD_CYC = 6. With these values each write finishes in a few dozen clocks, so one run can cover several complete writes, the rejected starts and a discharge wait that is cut short. Pointer values above 127 with a nonzero high byte exercise the address reduction. START_FALLS keeps its value of 4, so the count of qualifying clock edges is the real one.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ARM   = 3'd1,
    PH_ERASE = 3'd2,
    PH_PROG  = 3'd3,
    PH_HOLD  = 3'd4
  } phase_t;

  localparam logic [1:0] RI_CTRL = 2'd0;
  localparam logic [1:0] RI_PTRL = 2'd1;
  localparam logic [1:0] RI_PTRH = 2'd2;
  localparam logic [1:0] RI_DATA = 2'd3;

  localparam int B_MEMSEL = 7;
  localparam int B_CFGSEL = 6;
  localparam int B_WREN   = 2;
  localparam int B_WR     = 1;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/nvw_falldet.sv
module nvw_falldet (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/nvw_regs.sv
module nvw_regs
  import nvw_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          busy,
  output logic [7:0]    reg_rdata,
  output logic          start,
  output logic [AW-1:0] ptr,
  output logic [7:0]    data
);
  logic       memsel_q, cfgsel_q, wren_q, wr_q;
  logic [7:0] ptrl_q, ptrh_q, data_q;
  logic       ctrl_wr;
  logic       legal;

  assign ctrl_wr = reg_we && (reg_addr == RI_CTRL);
  assign legal   = wren_q && reg_wdata[B_WREN] &&
                   !reg_wdata[B_MEMSEL] && !reg_wdata[B_CFGSEL];
  assign start   = ctrl_wr && !busy && reg_wdata[B_WR] && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      memsel_q <= 1'b0;
      cfgsel_q <= 1'b0;
      wren_q   <= 1'b0;
      wr_q     <= 1'b0;
      ptrl_q   <= '0;
      ptrh_q   <= '0;
      data_q   <= '0;
    end else begin
      if (wr_q && !busy) wr_q <= 1'b0;
      if (reg_we) begin
        if (busy) begin
          if (reg_addr == RI_CTRL) wren_q <= wren_q & reg_wdata[B_WREN];
        end else begin
          unique case (reg_addr)
            RI_CTRL: begin
              memsel_q <= reg_wdata[B_MEMSEL];
              cfgsel_q <= reg_wdata[B_CFGSEL];
              wren_q   <= reg_wdata[B_WREN];
              if (reg_wdata[B_WR]) wr_q <= 1'b1;
            end
            RI_PTRL: ptrl_q <= reg_wdata;
            RI_PTRH: ptrh_q <= reg_wdata;
            RI_DATA: data_q <= reg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        RI_CTRL: reg_rdata <= {memsel_q, cfgsel_q, 3'b000, wren_q, wr_q, 1'b0};
        RI_PTRL: reg_rdata <= ptrl_q;
        RI_PTRH: reg_rdata <= ptrh_q;
        default: reg_rdata <= data_q;
      endcase
    end
  end

  logic [15:0] ptr_full;
  assign ptr_full = {ptrh_q, ptrl_q};
  assign ptr      = ptr_full[AW-1:0];
  assign data     = data_q;

  // R3: a sequence only ever starts from an enable bit stored beforehand
  p_wren_before_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wren_q));

  // R4: a rejected start bit is visible for one cycle, then gone
  p_reject_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !busy && reg_wdata[B_WR] && !legal) |=> (wr_q && !busy) ##1 !wr_q);

  // R9: pointer and data hold while a sequence runs
  p_busy_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(data_q) && $stable(ptrl_q) && $stable(ptrh_q)));

  // R8: start bit stays up for the whole sequence
  p_wr_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> wr_q);
endmodule

// File: rtl/nvw_seq.sv
module nvw_seq
  import nvw_pkg::*;
#(
  parameter int AW          = 7,
  parameter int START_FALLS = 4,
  parameter int ERASE_CYC   = 16,
  parameter int PROG_CYC    = 32,
  parameter int HOLD_CYC    = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fall,
  input  logic          pclk_lvl,
  input  logic [AW-1:0] ptr,
  input  logic [7:0]    data,
  output logic          busy,
  output logic          done,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata
);
  localparam int MAX_AB = (START_FALLS > ERASE_CYC) ? START_FALLS : ERASE_CYC;
  localparam int MAX_CD = (PROG_CYC > HOLD_CYC) ? PROG_CYC : HOLD_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXC + 1);

  phase_t        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      PH_IDLE: if (start) begin
        state_d = PH_ARM;
        cnt_d   = '0;
      end
      PH_ARM: if (fall) begin
        if (cnt_q == CW'(START_FALLS - 1)) begin
          state_d = PH_ERASE;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      PH_ERASE: begin
        if (cnt_q == CW'(ERASE_CYC - 1)) begin
          state_d = PH_PROG;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      PH_PROG: begin
        if (cnt_q == CW'(PROG_CYC - 1)) begin
          state_d = PH_HOLD;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      PH_HOLD: begin
        if (pclk_lvl) cnt_d = '0;
        else if (cnt_q == CW'(HOLD_CYC - 1)) begin
          state_d = PH_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: begin
        state_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PH_IDLE;
      cnt_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      busy      <= (state_d != PH_IDLE);
      done      <= done_d;
      arr_we    <= (state_d == PH_ERASE) || (state_d == PH_PROG);
      arr_addr  <= ptr;
      arr_wdata <= (state_d == PH_ERASE) ? ERASED_BYTE : data;
    end
  end

  // R6: the array is only touched inside a sequence
  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  // R6: programming is always entered from the erase phase
  p_erase_first_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_PROG && $past(state_q) != PH_PROG) |-> $past(state_q) == PH_ERASE);

  // R5: leaving the armed wait needs a falling programming-clock edge
  p_start_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_ERASE && $past(state_q) == PH_ARM) |-> $past(fall));

  // R7: a high programming clock during discharge keeps the sequence busy
  p_hold_low_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_HOLD && pclk_lvl) |=> busy);

  // R7: done is a single-cycle pulse seen with busy low
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));
endmodule

// File: rtl/nvbyte_write_ctrl.sv
module nvbyte_write_ctrl #(
  parameter int DEPTH       = 128,
  parameter int START_FALLS = 4,
  parameter int ERASE_CYC   = 16,
  parameter int PROG_CYC    = 32,
  parameter int HOLD_CYC    = 20,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          prog_clk,
  output logic          busy,
  output logic          done,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata
);
  logic          start, fall;
  logic [AW-1:0] ptr;
  logic [7:0]    data;

  nvw_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .reg_rdata(reg_rdata),
    .start(start), .ptr(ptr), .data(data)
  );

  nvw_falldet fall_i (
    .clk(clk), .rst(rst), .lvl(prog_clk), .fall(fall)
  );

  nvw_seq #(
    .AW(AW), .START_FALLS(START_FALLS), .ERASE_CYC(ERASE_CYC),
    .PROG_CYC(PROG_CYC), .HOLD_CYC(HOLD_CYC)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start), .fall(fall), .pclk_lvl(prog_clk),
    .ptr(ptr), .data(data), .busy(busy), .done(done), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );
endmodule

// File: tb/nvbyte_write_ctrl_tb_top.sv
module nvbyte_write_ctrl_tb_top;
  localparam int DEPTH = 128;
  localparam int AW    = $clog2(DEPTH);
  localparam int EC    = 3;
  localparam int PC    = 5;
  localparam int HC    = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [7:0]    reg_wdata = 8'd0;
  logic [7:0]    reg_rdata;
  logic          prog_clk = 1'b0;
  logic          busy, done, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_wdata;

  always #5 clk = ~clk;

  nvbyte_write_ctrl #(
    .DEPTH(DEPTH), .START_FALLS(4), .ERASE_CYC(EC), .PROG_CYC(PC), .HOLD_CYC(HC)
  ) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prog_clk(prog_clk),
    .busy(busy), .done(done), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata)
  );

  // external array: a plain register file
  logic [7:0] mem [DEPTH];
  int         we_events;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h3C;
      we_events <= 0;
    end else if (arr_we) begin
      mem[arr_addr] <= arr_wdata;
      we_events <= we_events + 1;
    end
  end

  // behavioural reference model
  int         m_phase, m_cnt;
  bit         m_prev, m_wren, m_done;
  bit [15:0]  m_addr;
  bit [7:0]   m_data;
  bit [7:0]   exp_mem [DEPTH];
  always @(posedge clk) begin
    bit fl, busy_now;
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_prev = 0; m_wren = 0; m_done = 0;
      m_addr = 0; m_data = 0;
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h3C;
    end else begin
      fl = m_prev && !prog_clk;
      m_prev = prog_clk;
      busy_now = (m_phase != 0);
      m_done = 0;
      case (m_phase)
        1: if (fl) begin
             if (m_cnt == 3) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
           end
        2: if (m_cnt == EC - 1) begin m_phase = 3; m_cnt = 0; end else m_cnt++;
        3: if (m_cnt == PC - 1) begin m_phase = 4; m_cnt = 0; end else m_cnt++;
        4: if (prog_clk) m_cnt = 0;
           else if (m_cnt == HC - 1) begin
             m_phase = 0; m_cnt = 0; m_done = 1;
             exp_mem[m_addr % DEPTH] = m_data;
           end else m_cnt++;
        default: ;
      endcase
      if (reg_we) begin
        case (reg_addr)
          2'd0: if (busy_now) m_wren = m_wren & reg_wdata[2];
                else begin
                  if (reg_wdata[1] && m_wren && reg_wdata[2] && reg_wdata[7:6] == 2'b00) begin
                    m_phase = 1; m_cnt = 0;
                  end
                  m_wren = reg_wdata[2];
                end
          2'd1: if (!busy_now) m_addr[7:0] = reg_wdata;
          2'd2: if (!busy_now) m_addr[15:8] = reg_wdata;
          default: if (!busy_now) m_data = reg_wdata;
        endcase
      end
    end
  end

  // per-cycle comparison and watchdog
  int checks = 0, errors = 0, cchecks = 0, cerrors = 0, cycles = 0;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks + cchecks, errors + cerrors);
  endtask

  always @(negedge clk) begin
    bit         e_we;
    logic [7:0] e_wd;
    cycles++;
    if (cycles > 150000) begin
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      cerrors++;
      summary();
      $finish;
    end
    if (!rst) begin
      e_we = (m_phase == 2) || (m_phase == 3);
      e_wd = (m_phase == 2) ? 8'hFF : m_data;
      cchecks++;
      if (busy !== (m_phase != 0) || done !== m_done) begin
        cerrors++;
        $display("FAIL R7 busy/done actual %b/%b expected %b/%b", busy, done, m_phase != 0, m_done);
      end
      if (arr_we !== e_we ||
          (e_we && (arr_wdata !== e_wd || arr_addr !== AW'(m_addr % DEPTH)))) begin
        cerrors++;
        $display("FAIL R6 array we/addr/data actual %b/%h/%h expected %b/%h/%h",
                 arr_we, arr_addr, arr_wdata, e_we, AW'(m_addr % DEPTH), e_wd);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic falls(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); prog_clk = 1'b1;
      @(negedge clk);
      @(negedge clk); prog_clk = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 done/we", {done, arr_we}, 0);
    rreg(2'd0, 8'h00, "R1 ctrl");
    rreg(2'd3, 8'h00, "R1 data");

    // R2: register readback
    wreg(2'd1, 8'h05);
    wreg(2'd2, 8'h00);
    wreg(2'd3, 8'hA5);
    rreg(2'd1, 8'h05, "R2 ptr low");
    rreg(2'd3, 8'hA5, "R2 data");
    wreg(2'd0, 8'h04);
    rreg(2'd0, 8'h04, "R2 ctrl enable");

    // R3/R5/R6/R8: a legal write
    wreg(2'd0, 8'h06);
    chk("R3 busy after start", busy, 1);
    rreg(2'd0, 8'h06, "R3 start bit while busy");
    falls(3);
    repeat (3) @(negedge clk);
    chk("R5 no array write before 4th fall", we_events, 0);
    chk("R5 still busy", busy, 1);
    falls(1);
    wait_idle();
    @(negedge clk);
    rreg(2'd0, 8'h04, "R8 start bit cleared");
    chk("R6 byte programmed", mem[5], 8'hA5);
    chk("R6 erase+program strobes", we_events, EC + PC);

    // R4: rejected starts
    wreg(2'd0, 8'h00);
    wreg(2'd3, 8'h11);
    wreg(2'd0, 8'h06);        // enable was 0 beforehand
    repeat (2) @(negedge clk);
    chk("R4 no busy, enable not prior", busy, 0);
    rreg(2'd0, 8'h04, "R4 start bit dropped");
    wreg(2'd0, 8'h86);        // memory-region select set
    falls(4);
    chk("R4 no busy, region select", busy, 0);
    wreg(2'd0, 8'h04);
    wreg(2'd0, 8'h46);        // configuration select set
    falls(4);
    chk("R4 no busy, config select", busy, 0);
    chk("R4 array untouched", we_events, EC + PC);
    rreg(2'd0, 8'h44, "R4 other bits kept");

    // R10: pointer reduced to the array depth
    wreg(2'd0, 8'h04);
    wreg(2'd1, 8'hF3);
    wreg(2'd2, 8'h12);
    wreg(2'd3, 8'h5A);
    wreg(2'd0, 8'h06);
    falls(4);
    wait_idle();
    chk("R10 masked address", mem[7'h73], 8'h5A);

    // R9: writes while busy, enable cleared mid-sequence
    wreg(2'd1, 8'h20);
    wreg(2'd2, 8'h00);
    wreg(2'd3, 8'hC3);
    wreg(2'd0, 8'h06);
    wreg(2'd3, 8'h00);
    wreg(2'd1, 8'h21);
    wreg(2'd0, 8'hC2);
    falls(4);
    // R7: high blip during discharge restarts the count
    repeat (EC + PC + 2) @(negedge clk);
    prog_clk = 1'b1;
    repeat (2) @(negedge clk);
    prog_clk = 1'b0;
    repeat (HC - 2) @(negedge clk);
    chk("R7 hold restarted, still busy", busy, 1);
    wait_idle();
    @(negedge clk);
    chk("R9 original byte written", mem[8'h20 % DEPTH], 8'hC3);
    chk("R9 neighbour untouched", mem[8'h21 % DEPTH], 8'h3C);
    rreg(2'd3, 8'hC3, "R9 data kept");
    rreg(2'd0, 8'h00, "R9 enable cleared, region bits kept");

    // final array comparison
    for (int i = 0; i < DEPTH; i++) chk("R6 array contents", mem[i], exp_mem[i]);

    summary();
    $finish;
  end
endmodule